// File: doc/BRIEF.md
# LCD Frame Clock Generator

This block derives the frame timing of an LCD panel from the system clock. It does this without creating any new clock. A one-byte configuration register picks the source rate. The source is either a synchronized tick taken from the low-frequency subsystem oscillator, or the system clock divided by 64, 128 or 256. The same register picks a second divide stage of 64, 128, 256 or 512, which gives the reference rate. A last counter splits each frame into one, three or four common phases, chosen by the display duty input. It emits the current phase index and a single-cycle frame pulse.

The configuration register is guarded. A write is accepted only while the display, the segment/common drive and the voltage booster are all disabled. Any other write to the register's address is dropped and sets a sticky error flag. While the display is off, every divider and the phase counter are held cleared. The first frame after enabling therefore always starts from a known point.

Top module: `lcd_frame_clkgen`

## Requirements
- R1: After reset, bus_rdata reads 0x00, com_idx is 0, frame_pulse is 0 and cfg_err is 0.
- R2: A write to address 0xFF91 with all three enables low stores wdata bits 3:0. Bits 7:4 of bus_rdata always read 0.
- R3: A write to any other address leaves the register unchanged and does not set cfg_err.
- R4: Register bits 3:2 select the source tick: 00 passes sub_tick through, and 01, 10 and 11 give one tick every 64, 128 and 256 system cycles.
- R5: Register bits 1:0 give one reference tick per 64 (00), 128 (01), 256 (10) or 512 (11) source ticks.
- R6: duty_sel 00 gives one phase, 01 three phases and 10 four phases, and 11 behaves as 00. com_idx advances by one on each reference tick and wraps from the last phase to 0.
- R7: frame_pulse is high for exactly one cycle, in the cycle where com_idx has just wrapped to 0. It therefore appears once every N reference periods.
- R8: A write to 0xFF91 while disp_on, drive_en or boost_en is high leaves the register unchanged.
- R9: A blocked write as in R8 sets cfg_err, and cfg_err stays high until reset.
- R10: While disp_on is low, com_idx is 0 and frame_pulse is 0. When disp_on is raised, the first phase change comes after exactly one full reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Current register value |
| sub_tick | input | 1 | Synchronized one-cycle tick from the subsystem oscillator |
| disp_on | input | 1 | Display enable; the dividers run only while it is high |
| drive_en | input | 1 | Segment/common output enable (locks the register) |
| boost_en | input | 1 | Voltage booster enable (locks the register) |
| duty_sel | input | 2 | Display duty: 00 static, 01 one-third, 10 one-quarter, 11 static |
| com_idx | output | 2 | Current common-phase index |
| frame_pulse | output | 1 | One-cycle pulse at each frame start |
| cfg_err | output | 1 | Sticky flag for a blocked register write |

## Verification
The timing chain is tested in both source modes. In subsystem mode sub_tick is held high every cycle, so each reference divisor and each duty can be told apart within a few thousand cycles. Runs with the system-clock prescaler at 64, 128 and 256 show that the prescaler taps are distinct and that the subsystem tick is no longer used. A run with sub_tick held low shows that nothing advances without source ticks. For each pattern, the bench measures the cycle of the first phase change, the cycles of the first two frame pulses, the pulse count and the highest phase index. Errors in the divisor, the phase count, the pulse width and the start alignment each move a different one of these numbers.

// File: rtl/lcdfc_pkg.sv
package lcdfc_pkg;

  typedef enum logic [1:0] {
    DUTY_STATIC  = 2'b00,
    DUTY_THIRD   = 2'b01,
    DUTY_QUARTER = 2'b10,
    DUTY_RSVD    = 2'b11
  } duty_e;

  typedef struct packed {
    logic [1:0] src_sel;
    logic [1:0] ref_sel;
  } clkcfg_t;

  // index of the last common phase for a given duty
  function automatic logic [1:0] last_phase(input duty_e duty);
    case (duty)
      DUTY_THIRD:   last_phase = 2'd2;
      DUTY_QUARTER: last_phase = 2'd3;
      default:      last_phase = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/lcdfc_cfg_reg.sv
module lcdfc_cfg_reg
  import lcdfc_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 16'hFF91
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              lock,
  output clkcfg_t           cfg,
  output logic [7:0]        rdata,
  output logic              err
);

  localparam logic [7:0] WMASK = 8'h0F;

  logic [7:0] data_q, data_d;
  logic       err_q, err_d;
  logic       hit;

  assign hit = wr_en && (wr_addr == REG_ADDR);

  always_comb begin
    data_d = data_q;
    err_d  = err_q;
    if (hit) begin
      if (lock) err_d  = 1'b1;
      else      data_d = wr_data & WMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 8'h00;
      err_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      err_q  <= err_d;
    end
  end

  assign rdata = data_q;
  assign cfg   = clkcfg_t'(data_q[3:0]);
  assign err   = err_q;

  // R8
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && lock) |=> $stable(rdata));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:4] == 4'h0);

endmodule

// File: rtl/lcdfc_src_div.sv
module lcdfc_src_div #(
  parameter int unsigned BASE_LOG2 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       sub_tick,
  output logic       src_tick
);

  localparam int unsigned CW = BASE_LOG2 + 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    tap;

  assign tap[0] = sub_tick;

  generate
    for (genvar g = 1; g < 4; g++) begin : g_tap
      assign tap[g] = &cnt_q[BASE_LOG2+g-2:0];
    end
  endgenerate

  always_comb begin
    if (run) cnt_d = cnt_q + CW'(1);
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign src_tick = run & tap[sel];

  // R4
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_tick && sel != 2'b00 && $stable(sel)) |=> !src_tick);

endmodule

// File: rtl/lcdfc_ref_div.sv
module lcdfc_ref_div #(
  parameter int unsigned BASE_LOG2 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       src_tick,
  input  logic [1:0] sel,
  output logic       ref_tick
);

  localparam int unsigned CW = BASE_LOG2 + 3;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    tap;

  generate
    for (genvar g = 0; g < 4; g++) begin : g_tap
      assign tap[g] = &cnt_q[BASE_LOG2+g-1:0];
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (!run)          cnt_d = '0;
    else if (src_tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ref_tick = run & src_tick & tap[sel];

  // R5
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);

endmodule

// File: rtl/lcdfc_phase_ctr.sv
module lcdfc_phase_ctr
  import lcdfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ref_tick,
  input  duty_e      duty,
  output logic [1:0] com_idx,
  output logic       frame_pulse
);

  logic [1:0] idx_q, idx_d;
  logic       pulse_q, pulse_d;
  logic       at_last;

  assign at_last = (idx_q >= last_phase(duty));

  always_comb begin
    idx_d   = idx_q;
    pulse_d = 1'b0;
    if (!run) begin
      idx_d = 2'd0;
    end else if (ref_tick) begin
      idx_d   = at_last ? 2'd0 : idx_q + 2'd1;
      pulse_d = at_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= 2'd0;
      pulse_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      pulse_q <= pulse_d;
    end
  end

  assign com_idx     = idx_q;
  assign frame_pulse = pulse_q;

  // R7
  pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (com_idx == 2'd0));

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse);

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (com_idx == 2'd0 && !frame_pulse));

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ref_tick && $past(run)) |=> $stable(com_idx));

endmodule

// File: rtl/lcd_frame_clkgen.sv
module lcd_frame_clkgen
  import lcdfc_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR      = 16'hFF91,
  parameter int unsigned       SRC_BASE_LOG2 = 6,
  parameter int unsigned       REF_BASE_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              sub_tick,
  input  logic              disp_on,
  input  logic              drive_en,
  input  logic              boost_en,
  input  logic [1:0]        duty_sel,
  output logic [1:0]        com_idx,
  output logic              frame_pulse,
  output logic              cfg_err
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  clkcfg_t    cfg;
  logic       lock;
  logic       src_tick;
  logic       ref_tick;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign lock = disp_on | drive_en | boost_en;

  lcdfc_cfg_reg #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (bus_wr),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .lock    (lock),
    .cfg     (cfg),
    .rdata   (bus_rdata),
    .err     (cfg_err)
  );

  lcdfc_src_div #(.BASE_LOG2(SRC_BASE_LOG2)) u_src (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (disp_on),
    .sel      (cfg.src_sel),
    .sub_tick (sub_tick),
    .src_tick (src_tick)
  );

  lcdfc_ref_div #(.BASE_LOG2(REF_BASE_LOG2)) u_ref (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (disp_on),
    .src_tick (src_tick),
    .sel      (cfg.ref_sel),
    .ref_tick (ref_tick)
  );

  lcdfc_phase_ctr u_phase (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .run         (disp_on),
    .ref_tick    (ref_tick),
    .duty        (duty_e'(duty_sel)),
    .com_idx     (com_idx),
    .frame_pulse (frame_pulse)
  );

endmodule

// File: tb/sim_lcd_frame_clkgen.sv
module sim_lcd_frame_clkgen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        sub_tick = 1'b0;
  logic        disp_on = 1'b0;
  logic        drive_en = 1'b0;
  logic        boost_en = 1'b0;
  logic [1:0]  duty_sel = 2'b00;
  logic [1:0]  com_idx;
  logic        frame_pulse;
  logic        cfg_err;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lcd_frame_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_tick(sub_tick),
    .disp_on(disp_on), .drive_en(drive_en), .boost_en(boost_en),
    .duty_sel(duty_sel), .com_idx(com_idx), .frame_pulse(frame_pulse),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk(bus_rdata == 8'h00, "R1", "rdata", bus_rdata, 0);
    chk(com_idx == 2'd0, "R1", "com_idx", com_idx, 0);
    chk(frame_pulse == 1'b0, "R1", "frame_pulse", frame_pulse, 0);
    chk(cfg_err == 1'b0, "R1", "cfg_err", cfg_err, 0);
  endtask

  task automatic t_regs();
    wr(16'hFF91, 8'hFF);
    chk(bus_rdata == 8'h0F, "R2", "upper bits masked", bus_rdata, 8'h0F);
    wr(16'hFF91, 8'hA6);
    chk(bus_rdata == 8'h06, "R2", "store low nibble", bus_rdata, 8'h06);
    wr(16'hFF90, 8'h09);
    chk(bus_rdata == 8'h06, "R3", "other address", bus_rdata, 8'h06);
    chk(cfg_err == 1'b0, "R3", "no error on other address", cfg_err, 0);
  endtask

  task automatic t_lock();
    @(negedge clk) drive_en = 1'b1;
    wr(16'hFF91, 8'h03);
    chk(bus_rdata == 8'h06, "R8", "blocked by drive_en", bus_rdata, 8'h06);
    chk(cfg_err == 1'b1, "R9", "error set", cfg_err, 1);
    drive_en = 1'b0; boost_en = 1'b1;
    wr(16'hFF91, 8'h0C);
    chk(bus_rdata == 8'h06, "R8", "blocked by boost_en", bus_rdata, 8'h06);
    boost_en = 1'b0; disp_on = 1'b1;
    wr(16'hFF91, 8'h0D);
    chk(bus_rdata == 8'h06, "R8", "blocked by disp_on", bus_rdata, 8'h06);
    disp_on = 1'b0;
    wr(16'hFF91, 8'h01);
    chk(bus_rdata == 8'h01, "R2", "write after unlock", bus_rdata, 1);
    chk(cfg_err == 1'b1, "R9", "error sticky", cfg_err, 1);
  endtask

  // run one configuration: per = cycles per phase, nph = phases per frame
  task automatic measure(input string tag, input logic [7:0] cfg,
                         input logic [1:0] duty, input int per, input int nph);
    int first_p = -1;
    int second_p = -1;
    int npulse = 0;
    int maxidx = 0;
    int idx_at = -1;
    wr(16'hFF91, cfg);
    duty_sel = duty;
    @(negedge clk) disp_on = 1'b1;
    for (int c = 1; c <= 2 * nph * per + 2; c++) begin
      @(posedge clk); #1;
      if (frame_pulse) begin
        npulse++;
        if (first_p < 0) first_p = c;
        else if (second_p < 0) second_p = c;
      end
      if (int'(com_idx) > maxidx) maxidx = int'(com_idx);
      if (c == per) idx_at = int'(com_idx);
    end
    @(negedge clk) disp_on = 1'b0;
    @(negedge clk);
    chk(first_p == nph * per, tag, "first pulse cycle", first_p, nph * per);
    chk(second_p == 2 * nph * per, tag, "second pulse cycle", second_p, 2 * nph * per);
    chk(npulse == 2, tag, "pulse count", npulse, 2);
    chk(maxidx == nph - 1, tag, "max com_idx", maxidx, nph - 1);
    chk(idx_at == ((nph > 1) ? 1 : 0), tag, "idx after one period", idx_at,
        (nph > 1) ? 1 : 0);
    chk(com_idx == 2'd0, "R10", "cleared when off", com_idx, 0);
  endtask

  task automatic t_idle();
    int moved = 0;
    wr(16'hFF91, 8'h00);
    sub_tick = 1'b1;
    for (int c = 0; c < 300; c++) begin
      @(posedge clk); #1;
      if (com_idx != 2'd0 || frame_pulse) moved++;
    end
    chk(moved == 0, "R10", "held while off", moved, 0);
    sub_tick = 1'b0;
    duty_sel = 2'b10;
    @(negedge clk) disp_on = 1'b1;
    for (int c = 0; c < 300; c++) begin
      @(posedge clk); #1;
      if (com_idx != 2'd0 || frame_pulse) moved++;
    end
    chk(moved == 0, "R4", "no advance without sub_tick", moved, 0);
    @(negedge clk) disp_on = 1'b0;
    sub_tick = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_lock();
    t_idle();
    measure("R4/R5/R6/R7 sub ref64 static",  8'h00, 2'b00, 64,    1);
    measure("R5/R6/R7 sub ref128 third",     8'h01, 2'b01, 128,   3);
    measure("R5/R6/R7 sub ref256 quarter",   8'h02, 2'b10, 256,   4);
    measure("R5/R6 sub ref512 reserved",     8'h03, 2'b11, 512,   1);
    measure("R4 main div64 static",          8'h04, 2'b00, 4096,  1);
    measure("R4/R6 main div128 third",       8'h08, 2'b01, 8192,  3);
    measure("R4 main div256 static",         8'h0C, 2'b00, 16384, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule